// File: doc/BRIEF.md
# Wakeup Source Controller

This block collects eighteen wakeup request lines from always-on logic and decides when the host should be brought out of deep sleep. A per-source enable mask chooses which lines can wake the host. A per-source type bit chooses between a slow, sequenced power-up and a fast wake that assumes supplies are already stable. Two of the eighteen positions do not come from the request input. They are built from 45 general-purpose inputs, each with its own selection mask: one is an AND reduction of the selected inputs and the other is an OR reduction.

Captured requests are held in a sticky status register that software clears by writing ones. A five-state host power machine reports its position as a fixed 3-bit code. It has these states: DEEP (100), PWR_UP (010), SHARED_UP (001), ACTIVE (011) and PWR_DN (000). It has these transitions: DEEP→ACTIVE (fast wake), DEEP→PWR_UP→SHARED_UP→ACTIVE (slow wake), and ACTIVE→PWR_DN→DEEP (sleep command). A simple word-addressed register bus reaches the masks, the status and the state code.

Top module: `wake_src_ctrl`

## Requirements
- R1: After reset the state code is 100 (DEEP). The enable and type registers read 0, all four GPIO mask registers read all ones in their used bits, and the status register reads 0.
- R2: Register addresses are: 0 enable, 1 wake type, 2 AND mask GPIO 0–31, 3 AND mask GPIO 32–44 (bits 12:0), 4 OR mask GPIO 0–31, 5 OR mask GPIO 32–44, 6 status, 7 state code (bits 2:0, read-only). Writes take effect on the clock edge with bus_en and bus_we high. Reads are combinational. Bits above a register's width read 0.
- R3: On the first edge where a source is requesting and its enable bit is 1, the matching status bit is set. A source whose enable bit is 0 never sets status.
- R4: Status bits stay set until a 1 is written to that bit at address 6. Writing 0 leaves the bit unchanged. If a request and a clear occur on the same edge, the bit stays set.
- R5: Source bit 1 is the AND of the GPIO inputs selected by the AND masks. An unselected input counts as 1. If no input is selected, the result is 0.
- R6: Source bit 2 is the OR of the GPIO inputs selected by the OR masks. An unselected input counts as 0.
- R7: The raw request lines at positions 1 and 2 have no effect. Those positions come only from the GPIO combiners.
- R8: In DEEP, if some enabled status bit is set and every such bit has type 1 (fast), the next state is ACTIVE (011).
- R9: In DEEP, if any enabled status bit with type 0 (slow) is set, the state moves to PWR_UP (010), then SHARED_UP (001), then ACTIVE (011), one state per cycle.
- R10: In ACTIVE, sleep_cmd moves the state to PWR_DN (000) and then to DEEP (100). In DEEP with no enabled status bit set, the state stays DEEP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | 18 | Raw wakeup request lines, one per source position |
| gpio_in | input | 45 | General-purpose inputs feeding the AND and OR combiners |
| sleep_cmd | input | 1 | Request to power the host down, acted on in ACTIVE |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| host_state | output | 3 | Current host power state code |

## Verification
A corrupted status bit shows on host_state one edge after it appears. A spurious bit moves the machine out of DEEP, and a lost bit leaves it parked there, so status read-back and the state code cross-check each other within two cycles of a request. A wrong wake-type decision shows in the very next state code: 010 appears where 011 was expected, or the reverse. The combiner and mask checks work the same way: the bench compares the status read-back against the value computed from the selected inputs, one edge after the inputs change.

// File: rtl/wsc_pkg.sv
package wsc_pkg;
    localparam int NUM_SRC      = 18;
    localparam int NUM_GPIO     = 45;
    localparam int DW           = 32;
    localparam int AW           = 3;
    localparam int SRC_GPIO_AND = 1;
    localparam int SRC_GPIO_OR  = 2;

    localparam logic [AW-1:0] A_ENABLE  = 3'd0;
    localparam logic [AW-1:0] A_TYPE    = 3'd1;
    localparam logic [AW-1:0] A_AND_LO  = 3'd2;
    localparam logic [AW-1:0] A_AND_HI  = 3'd3;
    localparam logic [AW-1:0] A_OR_LO   = 3'd4;
    localparam logic [AW-1:0] A_OR_HI   = 3'd5;
    localparam logic [AW-1:0] A_STATUS  = 3'd6;
    localparam logic [AW-1:0] A_STATE   = 3'd7;

    typedef enum logic [2:0] {
        ST_PWR_DN    = 3'b000,
        ST_SHARED_UP = 3'b001,
        ST_PWR_UP    = 3'b010,
        ST_ACTIVE    = 3'b011,
        ST_DEEP      = 3'b100
    } host_state_e;
endpackage

// File: rtl/wsc_gpio_comb.sv
module wsc_gpio_comb #(
    parameter int N = 45
) (
    input  logic [N-1:0] gpio,
    input  logic [N-1:0] and_mask,
    input  logic [N-1:0] or_mask,
    output logic         and_hit,
    output logic         or_hit
);
    logic [N-1:0] and_term;
    logic [N-1:0] or_term;

    for (genvar g = 0; g < N; g++) begin : g_term
        assign and_term[g] = gpio[g] | ~and_mask[g];
        assign or_term[g]  = gpio[g] &  or_mask[g];
    end

    assign and_hit = (|and_mask) & (&and_term);
    assign or_hit  = |or_term;
endmodule

// File: rtl/wsc_regs.sv
module wsc_regs
    import wsc_pkg::*;
#(
    parameter int NS = 18,
    parameter int NG = 45,
    parameter int W  = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_en,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [W-1:0]  bus_wdata,
    output logic [W-1:0]  bus_rdata,
    input  logic [NS-1:0] src_eff,
    input  logic [2:0]    state,
    output logic [NS-1:0] en_q,
    output logic [NS-1:0] type_q,
    output logic [NG-1:0] and_mask,
    output logic [NG-1:0] or_mask,
    output logic [NS-1:0] status_q,
    output logic [NS-1:0] clr_vec
);
    localparam int HI_W = NG - W;

    logic [W-1:0]    and_lo_q, or_lo_q;
    logic [HI_W-1:0] and_hi_q, or_hi_q;
    logic            wr;

    assign wr       = bus_en & bus_we;
    assign clr_vec  = (wr && bus_addr == A_STATUS) ? bus_wdata[NS-1:0] : '0;
    assign and_mask = {and_hi_q, and_lo_q};
    assign or_mask  = {or_hi_q, or_lo_q};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q     <= '0;
            type_q   <= '0;
            and_lo_q <= '1;
            and_hi_q <= '1;
            or_lo_q  <= '1;
            or_hi_q  <= '1;
        end else if (wr) begin
            unique case (bus_addr)
                A_ENABLE: en_q     <= bus_wdata[NS-1:0];
                A_TYPE:   type_q   <= bus_wdata[NS-1:0];
                A_AND_LO: and_lo_q <= bus_wdata;
                A_AND_HI: and_hi_q <= bus_wdata[HI_W-1:0];
                A_OR_LO:  or_lo_q  <= bus_wdata;
                A_OR_HI:  or_hi_q  <= bus_wdata[HI_W-1:0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~clr_vec) | (src_eff & en_q);
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_ENABLE: bus_rdata[NS-1:0]   = en_q;
            A_TYPE:   bus_rdata[NS-1:0]   = type_q;
            A_AND_LO: bus_rdata           = and_lo_q;
            A_AND_HI: bus_rdata[HI_W-1:0] = and_hi_q;
            A_OR_LO:  bus_rdata           = or_lo_q;
            A_OR_HI:  bus_rdata[HI_W-1:0] = or_hi_q;
            A_STATUS: bus_rdata[NS-1:0]   = status_q;
            A_STATE:  bus_rdata[2:0]      = state;
            default:  bus_rdata           = '0;
        endcase
    end
endmodule

// File: rtl/wsc_fsm.sv
module wsc_fsm
    import wsc_pkg::*;
#(
    parameter int NS = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NS-1:0] pend,
    input  logic [NS-1:0] wtype,
    input  logic          sleep_cmd,
    output logic [2:0]    state_code
);
    host_state_e cur_q, nxt;
    logic        wake, slow;

    assign wake = |pend;
    assign slow = |(pend & ~wtype);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= ST_DEEP;
        else        cur_q <= nxt;
    end

    always_comb begin
        nxt = cur_q;
        unique case (cur_q)
            ST_DEEP:      if (wake) nxt = slow ? ST_PWR_UP : ST_ACTIVE;
            ST_PWR_UP:    nxt = ST_SHARED_UP;
            ST_SHARED_UP: nxt = ST_ACTIVE;
            ST_ACTIVE:    if (sleep_cmd) nxt = ST_PWR_DN;
            ST_PWR_DN:    nxt = ST_DEEP;
            default:      nxt = ST_DEEP;
        endcase
    end

    assign state_code = cur_q;
endmodule

// File: rtl/wake_src_ctrl.sv
module wake_src_ctrl
    import wsc_pkg::*;
#(
    parameter int NUM_SRC  = wsc_pkg::NUM_SRC,
    parameter int NUM_GPIO = wsc_pkg::NUM_GPIO,
    parameter int DATA_W   = wsc_pkg::DW
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_SRC-1:0]  src_req,
    input  logic [NUM_GPIO-1:0] gpio_in,
    input  logic                sleep_cmd,
    input  logic                bus_en,
    input  logic                bus_we,
    input  logic [AW-1:0]       bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic [2:0]          host_state
);
    logic [NUM_SRC-1:0]  en_q, type_q, status_q, clr_vec, src_eff, pend;
    logic [NUM_GPIO-1:0] and_mask, or_mask;
    logic                and_hit, or_hit;

    wsc_gpio_comb #(.N(NUM_GPIO)) comb_i (
        .gpio(gpio_in), .and_mask(and_mask), .or_mask(or_mask),
        .and_hit(and_hit), .or_hit(or_hit)
    );

    always_comb begin
        src_eff               = src_req;
        src_eff[SRC_GPIO_AND] = and_hit;
        src_eff[SRC_GPIO_OR]  = or_hit;
    end

    wsc_regs #(.NS(NUM_SRC), .NG(NUM_GPIO), .W(DATA_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .src_eff(src_eff), .state(host_state), .en_q(en_q), .type_q(type_q),
        .and_mask(and_mask), .or_mask(or_mask), .status_q(status_q),
        .clr_vec(clr_vec)
    );

    assign pend = status_q & en_q;

    wsc_fsm #(.NS(NUM_SRC)) fsm_i (
        .clk(clk), .rst_n(rst_n), .pend(pend), .wtype(type_q),
        .sleep_cmd(sleep_cmd), .state_code(host_state)
    );
endmodule

// File: rtl/wsc_checker.sv
module wsc_checker #(
    parameter int NS = 18
) (
    input logic          clk,
    input logic          rst_n,
    input logic [2:0]    state,
    input logic [NS-1:0] status,
    input logic [NS-1:0] en,
    input logic [NS-1:0] wtype,
    input logic [NS-1:0] clr,
    input logic          sleep_cmd
);
    logic [NS-1:0] pend;
    assign pend = status & en;

    assert_state_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
        state <= 3'b100);

    assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((($past(status) & ~$past(clr)) & ~status) == '0));

    assert_fast_wake_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 3'b100 && (|pend) && !(|(pend & ~wtype))) |=> state == 3'b011);

    assert_slow_wake_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 3'b100 && (|(pend & ~wtype))) |=> state == 3'b010);

    assert_pwrup_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        state == 3'b010 |=> state == 3'b001);

    assert_shared_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        state == 3'b001 |=> state == 3'b011);

    assert_sleep_entry_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 3'b011 && sleep_cmd) |=> state == 3'b000);

    assert_pwrdn_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        state == 3'b000 |=> state == 3'b100);

    assert_stay_deep_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 3'b100 && !(|pend)) |=> state == 3'b100);
endmodule

bind wake_src_ctrl wsc_checker #(.NS(NUM_SRC)) chk_i (
    .clk(clk), .rst_n(rst_n), .state(host_state), .status(status_q),
    .en(en_q), .wtype(type_q), .clr(clr_vec), .sleep_cmd(sleep_cmd)
);

// File: tb/wake_src_ctrl_tb_top.sv
module wake_src_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [17:0] src_req = '0;
    logic [44:0] gpio_in = '0;
    logic        sleep_cmd = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [2:0]  host_state;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    wake_src_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .src_req(src_req), .gpio_in(gpio_in),
        .sleep_cmd(sleep_cmd), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .host_state(host_state)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic tidy();
        src_req = '0; gpio_in = '0;
        wr(3'd0, 32'h0);
        wr(3'd6, 32'h3FFFF);
        repeat (3) @(negedge clk);
        if (host_state == 3'b011) begin
            sleep_cmd = 1'b1; @(negedge clk); sleep_cmd = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 state port", {29'b0, host_state}, 32'h4);
        rd(3'd0, d); check("R1 enable", d, 32'h0);
        rd(3'd1, d); check("R1 type", d, 32'h0);
        rd(3'd2, d); check("R1 and lo", d, 32'hFFFFFFFF);
        rd(3'd3, d); check("R1 and hi", d, 32'h1FFF);
        rd(3'd4, d); check("R1 or lo", d, 32'hFFFFFFFF);
        rd(3'd5, d); check("R1 or hi", d, 32'h1FFF);
        rd(3'd6, d); check("R1 status", d, 32'h0);
        rd(3'd7, d); check("R1 state reg", d, 32'h4);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        wr(3'd1, 32'hFFFFFFFF); rd(3'd1, d); check("R2 type width", d, 32'h3FFFF);
        wr(3'd1, 32'h0);
        wr(3'd3, 32'hFFFFE000); rd(3'd3, d); check("R2 and hi width", d, 32'h0);
        wr(3'd4, 32'h12345678); rd(3'd4, d); check("R2 or lo", d, 32'h12345678);
        rd(3'd7, d); check("R2 state addr", d, 32'h4);
    endtask

    task automatic t_enable();
        logic [31:0] d;
        src_req = 18'h20;
        @(negedge clk); @(negedge clk);
        rd(3'd6, d); check("R3 disabled no status", d, 32'h0);
        check("R10 stays deep", {29'b0, host_state}, 32'h4);
        src_req = '0;
        wr(3'd0, 32'h20); wr(3'd1, 32'h20);
        src_req = 18'h20;
        @(negedge clk);
        rd(3'd6, d); check("R3 enabled sets status", d, 32'h20);
        tidy();
    endtask

    task automatic t_sticky();
        logic [31:0] d;
        wr(3'd0, 32'h10); wr(3'd1, 32'h10);
        src_req = 18'h10; @(negedge clk); src_req = '0;
        @(negedge clk);
        rd(3'd6, d); check("R4 sticky", d, 32'h10);
        wr(3'd6, 32'h8); rd(3'd6, d); check("R4 other bit clear", d, 32'h10);
        src_req = 18'h10; wr(3'd6, 32'h10);
        rd(3'd6, d); check("R4 set beats clear", d, 32'h10);
        src_req = '0; wr(3'd6, 32'h10);
        rd(3'd6, d); check("R4 w1c", d, 32'h0);
        tidy();
    endtask

    task automatic t_gpio_and();
        logic [31:0] d;
        wr(3'd2, 32'h5); wr(3'd3, 32'h0); wr(3'd4, 32'h0); wr(3'd5, 32'h0);
        wr(3'd0, 32'h2); wr(3'd1, 32'h2);
        gpio_in = 45'h1; @(negedge clk);
        rd(3'd6, d); check("R5 and partial", d, 32'h0);
        gpio_in = 45'h5; @(negedge clk);
        rd(3'd6, d); check("R5 and all selected", d, 32'h2);
        tidy();
        wr(3'd2, 32'h0); wr(3'd0, 32'h2); wr(3'd1, 32'h2);
        gpio_in = '1; @(negedge clk);
        rd(3'd6, d); check("R5 and empty selection", d, 32'h0);
        tidy();
    endtask

    task automatic t_gpio_or();
        logic [31:0] d;
        wr(3'd4, 32'h0); wr(3'd5, 32'h1);
        wr(3'd0, 32'h4); wr(3'd1, 32'h4);
        gpio_in = 45'h20; @(negedge clk);
        rd(3'd6, d); check("R6 or unselected", d, 32'h0);
        gpio_in = 45'h1_0000_0000; @(negedge clk);
        rd(3'd6, d); check("R6 or gpio32", d, 32'h4);
        tidy();
    endtask

    task automatic t_raw_ignored();
        logic [31:0] d;
        wr(3'd2, 32'h0); wr(3'd3, 32'h0); wr(3'd4, 32'h0); wr(3'd5, 32'h0);
        wr(3'd0, 32'h6); wr(3'd1, 32'h6);
        src_req = 18'h6; @(negedge clk); @(negedge clk);
        rd(3'd6, d); check("R7 raw bits ignored", d, 32'h0);
        check("R7 no wake", {29'b0, host_state}, 32'h4);
        tidy();
    endtask

    task automatic t_fast();
        wr(3'd0, 32'h8); wr(3'd1, 32'h8);
        src_req = 18'h8; @(negedge clk);
        check("R8 deep while capturing", {29'b0, host_state}, 32'h4);
        @(negedge clk);
        check("R8 fast to active", {29'b0, host_state}, 32'h3);
        src_req = '0; wr(3'd6, 32'h8);
        sleep_cmd = 1'b1; @(negedge clk); sleep_cmd = 1'b0;
        check("R10 power down", {29'b0, host_state}, 32'h0);
        @(negedge clk);
        check("R10 deep again", {29'b0, host_state}, 32'h4);
        tidy();
    endtask

    task automatic t_slow();
        wr(3'd0, 32'h20008); wr(3'd1, 32'h8);
        src_req = 18'h20008; @(negedge clk);
        @(negedge clk); check("R9 power up", {29'b0, host_state}, 32'h2);
        @(negedge clk); check("R9 shared up", {29'b0, host_state}, 32'h1);
        @(negedge clk); check("R9 active", {29'b0, host_state}, 32'h3);
        tidy();
        check("R10 back in deep", {29'b0, host_state}, 32'h4);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_enable();
        t_sticky();
        t_gpio_and();
        t_gpio_or();
        t_raw_ignored();
        t_fast();
        t_slow();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule